// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch Map

This block is the sequencing half of a microprogrammed control unit. It owns a 12-bit microaddress register that points into an external control store. It latches the control word read from that location into a microinstruction register, which drives the datapath for one cycle. The datapath itself is outside the block.

On every clock edge in run mode the next microaddress comes from one of four places, chosen by a two-bit field of the word being latched:
- the current address plus one;
- a branch target carried inside the word, taken only when a selected condition (optionally inverted) holds;
- the start address that a loadable table associates with the current instruction opcode;
- zero, which is the entry of the fetch microroutine.

The branch target has no bits of its own. It reuses the bits of the operand-register selector fields, so a branching word cannot also name registers. The opcode table is filled while the block is parked in load mode, normally once, at the same time the microcode is placed in the control store.

Top module: `microseq`

## Requirements
- R1: While `rst` is high at a clock edge, `cs_addr` becomes 0, `uir` becomes all zeros and every opcode-table entry becomes 0.
- R2: In run mode (`load_mode` low), a control word whose bits [1:0] are 00 makes the next `cs_addr` equal to the current one plus one, modulo 4096, so 4095 is followed by 0.
- R3: In run mode, at every clock edge `uir` takes the value of `cs_word` as it was just before that edge, which is the word stored at the current `cs_addr`.
- R4: A word with bits [1:0] = 01 whose condition holds makes the next `cs_addr` equal to bits [20:9] of that word. These are the two 5-bit register selectors at [20:16] and [15:11], followed by the upper two bits of the third selector at [10:6].
- R5: Bits [5:3] of the word pick the condition: value 0 is constant true, and value k from 1 to 7 is `status_flags[k-1]`. Bit [2] inverts the picked condition. When a 01 word's resulting condition is false, the next address is the current one plus one.
- R6: A word with bits [1:0] = 10 makes the next `cs_addr` equal to the table entry for the `ir_opcode` value present in that same cycle.
- R7: A word with bits [1:0] = 11 makes the next `cs_addr` equal to 0.
- R8: While `load_mode` is high, `cs_addr` and `uir` are held at 0. A cycle with `map_we` high writes `map_addr` into the entry selected by `map_opcode`. Once `load_mode` falls, execution resumes from address 0.
- R9: `map_we` has no effect while `load_mode` is low; later dispatches still return the previously loaded entries.
- R10: Dispatching on an opcode whose entry was never written since reset goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_mode | input | 1 | Parks the sequencer and enables opcode-table writes |
| map_we | input | 1 | Opcode-table write strobe (honoured only in load mode) |
| map_opcode | input | 6 | Opcode whose table entry is written |
| map_addr | input | 12 | Start address written into the table |
| ir_opcode | input | 6 | Opcode field of the current instruction |
| status_flags | input | 7 | Condition flags from the datapath |
| cs_addr | output | 12 | Current microaddress, read address of the control store |
| cs_word | input | 48 | Control-store word at `cs_addr` |
| uir | output | 48 | Microinstruction register, control word for this cycle |

## Verification
The embedded properties check the following relation on every cycle:
- each next-address source against the address that actually follows it: increment, taken and untaken branch, dispatch and fetch;
- the latching of the microinstruction register from the control store;
- the parking of both registers in load mode;
- that the table output cannot change in run mode unless the opcode changes.

Only the bench scenarios can show the rest:
- the exact bit positions of the branch target inside the selector fields;
- the mapping of each condition code to a particular flag together with the polarity bit;
- the wrap from 4095 to 0;
- that entries written in load mode are the ones later dispatched to, that unwritten entries yield zero, and that writes attempted in run mode are lost.

The bench compares both outputs with a reference model on each of a long run of random control words, flags and opcodes.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  // Next-address source codes held in control-word bits [1:0]
  typedef enum logic [1:0] {
    SRC_INC    = 2'b00,
    SRC_BRANCH = 2'b01,
    SRC_MAP    = 2'b10,
    SRC_FETCH  = 2'b11
  } nxt_src_e;

  // Field layout of the low part of the control word
  localparam int SRC_LO  = 0;
  localparam int POL_BIT = 2;
  localparam int CSEL_LO = 3;
  localparam int CSEL_W  = 3;
  localparam int SELC_LO = 6;
  localparam int SELB_LO = 11;
  localparam int SELA_LO = 16;
  localparam int RSEL_W  = 5;

  // Top bit of the branch target: the top of the first register selector
  localparam int BR_HI = SELA_LO + RSEL_W - 1;

endpackage

// File: rtl/microseq_cond.sv
module microseq_cond
  import microseq_pkg::*;
#(
  parameter int FLAG_N = 7
) (
  input  logic [CSEL_W-1:0] csel,
  input  logic              pol,
  input  logic [FLAG_N-1:0] flags,
  output logic              cond_true
);

  localparam int NSRC = 1 << CSEL_W;

  logic [NSRC-1:0] src_vec;

  // Source 0 is constant true; sources 1..FLAG_N are flags; the rest read false
  assign src_vec[0] = 1'b1;
  for (genvar k = 1; k < NSRC; k++) begin : g_src
    if (k <= FLAG_N) begin : g_flag
      assign src_vec[k] = flags[k-1];
    end else begin : g_none
      assign src_vec[k] = 1'b0;
    end
  end

  assign cond_true = src_vec[csel] ^ pol;

endmodule

// File: rtl/microseq_opmap.sv
module microseq_opmap #(
  parameter int OP_W = 6,
  parameter int UA_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [OP_W-1:0] wr_op,
  input  logic [UA_W-1:0] wr_addr,
  input  logic [OP_W-1:0] rd_op,
  output logic [UA_W-1:0] rd_addr
);

  localparam int DEPTH = 1 << OP_W;

  logic [UA_W-1:0] tbl [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar e = 0; e < DEPTH; e++) begin : g_hit
    assign hit[e] = wr_en && (wr_op == OP_W'(e));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (rst) begin
        tbl[e] <= '0;
      end else if (hit[e]) begin
        tbl[e] <= wr_addr;
      end
    end
  end

  assign rd_addr = tbl[rd_op];

endmodule

// File: rtl/microseq_nextaddr.sv
module microseq_nextaddr
  import microseq_pkg::*;
#(
  parameter int UA_W = 12
) (
  input  nxt_src_e        src,
  input  logic [UA_W-1:0] cur_addr,
  input  logic [UA_W-1:0] br_addr,
  input  logic [UA_W-1:0] map_start,
  input  logic            cond_true,
  output logic [UA_W-1:0] next_addr,
  output logic            go_inc,
  output logic            take_branch,
  output logic            dispatch,
  output logic            go_fetch
);

  function automatic logic [UA_W-1:0] step_addr(input logic [UA_W-1:0] a);
    return a + UA_W'(1);
  endfunction

  assign take_branch = (src == SRC_BRANCH) && cond_true;
  assign dispatch    = (src == SRC_MAP);
  assign go_fetch    = (src == SRC_FETCH);
  assign go_inc      = !take_branch && !dispatch && !go_fetch;

  always_comb begin
    next_addr = step_addr(cur_addr);
    if (take_branch) next_addr = br_addr;
    else if (dispatch) next_addr = map_start;
    else if (go_fetch) next_addr = '0;
  end

endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int UA_W   = 12,
  parameter int OP_W   = 6,
  parameter int FLAG_N = 7,
  parameter int UW     = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mode,
  input  logic              map_we,
  input  logic [OP_W-1:0]   map_opcode,
  input  logic [UA_W-1:0]   map_addr,
  input  logic [OP_W-1:0]   ir_opcode,
  input  logic [FLAG_N-1:0] status_flags,
  output logic [UA_W-1:0]   cs_addr,
  input  logic [UW-1:0]     cs_word,
  output logic [UW-1:0]     uir
);

  localparam int BR_LO = BR_HI - UA_W + 1;

  logic [UA_W-1:0]   uaddr_q;
  logic [UW-1:0]     uir_q;
  logic [UA_W-1:0]   next_addr;
  logic [UA_W-1:0]   map_start;
  logic [UA_W-1:0]   br_addr;
  logic [CSEL_W-1:0] csel;
  logic              pol;
  logic              cond_true;
  logic              map_wr;
  logic              go_inc, take_branch, dispatch, go_fetch;
  nxt_src_e          src;

  // Field extraction from the word at the current microaddress
  assign src     = nxt_src_e'(cs_word[SRC_LO +: 2]);
  assign pol     = cs_word[POL_BIT];
  assign csel    = cs_word[CSEL_LO +: CSEL_W];
  assign br_addr = cs_word[BR_HI:BR_LO];
  assign map_wr  = load_mode && map_we;

  microseq_cond #(.FLAG_N(FLAG_N)) u_cond (
    .csel      (csel),
    .pol       (pol),
    .flags     (status_flags),
    .cond_true (cond_true)
  );

  microseq_opmap #(.OP_W(OP_W), .UA_W(UA_W)) u_opmap (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (map_wr),
    .wr_op   (map_opcode),
    .wr_addr (map_addr),
    .rd_op   (ir_opcode),
    .rd_addr (map_start)
  );

  microseq_nextaddr #(.UA_W(UA_W)) u_next (
    .src         (src),
    .cur_addr    (uaddr_q),
    .br_addr     (br_addr),
    .map_start   (map_start),
    .cond_true   (cond_true),
    .next_addr   (next_addr),
    .go_inc      (go_inc),
    .take_branch (take_branch),
    .dispatch    (dispatch),
    .go_fetch    (go_fetch)
  );

  always_ff @(posedge clk) begin
    if (rst || load_mode) begin
      uaddr_q <= '0;
      uir_q   <= '0;
    end else begin
      uaddr_q <= next_addr;
      uir_q   <= cs_word;
    end
  end

  assign cs_addr = uaddr_q;
  assign uir     = uir_q;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (uaddr_q == '0 && uir_q == '0)); // R1
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (!load_mode && go_inc) |=> uaddr_q == $past(uaddr_q) + UA_W'(1)); // R2
  AST_UIR_LATCH: assert property (@(posedge clk) disable iff (rst)
    !load_mode |=> uir_q == $past(cs_word)); // R3
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!load_mode && take_branch) |=> uaddr_q == $past(br_addr)); // R4
  AST_BRANCH_FALLTHRU: assert property (@(posedge clk) disable iff (rst)
    (!load_mode && src == SRC_BRANCH && !cond_true) |=> uaddr_q == $past(uaddr_q) + UA_W'(1)); // R5
  AST_DISPATCH: assert property (@(posedge clk) disable iff (rst)
    (!load_mode && dispatch) |=> uaddr_q == $past(map_start)); // R6
  AST_FETCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!load_mode && go_fetch) |=> uaddr_q == '0); // R7
  AST_LOAD_PARK: assert property (@(posedge clk) disable iff (rst)
    load_mode |=> (uaddr_q == '0 && uir_q == '0)); // R8
  AST_MAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !load_mode && !$past(load_mode) && $stable(ir_opcode)) |-> $stable(map_start)); // R9

endmodule

// File: tb/microseq_bench.sv
module microseq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_mode = 1'b0;
  logic        map_we = 1'b0;
  logic [5:0]  map_opcode = '0;
  logic [11:0] map_addr = '0;
  logic [5:0]  ir_opcode = '0;
  logic [6:0]  status_flags = '0;
  logic [11:0] cs_addr;
  logic [47:0] cs_word;
  logic [47:0] uir;

  logic [47:0] mem [256];
  logic [11:0] mmap [64];
  logic [63:0] written;
  logic [11:0] e_addr;
  logic [47:0] e_uir;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign cs_word = mem[cs_addr[7:0]];

  microseq u_microseq (
    .clk(clk), .rst(rst), .load_mode(load_mode), .map_we(map_we),
    .map_opcode(map_opcode), .map_addr(map_addr), .ir_opcode(ir_opcode),
    .status_flags(status_flags), .cs_addr(cs_addr), .cs_word(cs_word), .uir(uir)
  );

  // Condition as defined by R5: code 0 true, code k picks flag k-1, bit 2 flips
  function automatic bit cond_of(input logic [47:0] w, input logic [6:0] f);
    bit c;
    c = (w[5:3] == 3'd0) ? 1'b1 : f[w[5:3] - 3'd1];
    return c ^ w[2];
  endfunction

  function automatic logic [11:0] pred_next(input logic [47:0] w, input logic [11:0] a,
                                            input logic [6:0] f, input logic [5:0] op);
    case (w[1:0])
      2'b01:   return cond_of(w, f) ? {w[20:16], w[15:11], w[10:9]} : a + 12'd1;
      2'b10:   return mmap[op];
      2'b11:   return 12'd0;
      default: return a + 12'd1;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: predict from the inputs now applied, then compare after the edge
  task automatic tick(input string force_tag = "");
    string tag_a, tag_u;
    logic [47:0] w;
    if (rst) begin
      e_addr = 0; e_uir = 0; written = '0;
      for (int i = 0; i < 64; i++) mmap[i] = 0;
      tag_a = "R1"; tag_u = "R1";
    end else if (load_mode) begin
      e_addr = 0; e_uir = 0;
      if (map_we) begin mmap[map_opcode] = map_addr; written[map_opcode] = 1'b1; end
      tag_a = "R8"; tag_u = "R8";
    end else begin
      w = mem[e_addr[7:0]];
      case (w[1:0])
        2'b00: tag_a = "R2";
        2'b01: tag_a = cond_of(w, status_flags) ? "R4" : "R5";
        2'b10: tag_a = written[ir_opcode] ? "R6" : "R10";
        default: tag_a = "R7";
      endcase
      if (map_we) tag_a = {tag_a, "/R9"};
      e_addr = pred_next(w, e_addr, status_flags, ir_opcode);
      e_uir = w;
      tag_u = "R3";
    end
    if (force_tag != "") tag_a = force_tag;
    @(posedge clk);
    #2;
    check(cs_addr === e_addr, tag_a, {36'd0, cs_addr}, {36'd0, e_addr});
    check(uir === e_uir, tag_u, uir, e_uir);
  endtask

  function automatic logic [47:0] mkw(input logic [1:0] src, input logic [2:0] csel,
                                      input bit pol, input logic [11:0] tgt);
    logic [47:0] w;
    w = {$urandom, $urandom};
    w[1:0] = src; w[2] = pol; w[5:3] = csel; w[20:9] = tgt;
    return w;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 48'd0;
    void'($urandom(32'h5eed_0042));
    #2;
    // R1: reset state
    tick("R1"); tick("R1");
    rst = 1'b0;
    // R8: load the opcode table while parked
    load_mode = 1'b1;
    map_we = 1'b1; map_opcode = 6'd5;  map_addr = 12'd40; tick("R8");
    map_opcode = 6'd63; map_addr = 12'd200; tick("R8");
    map_opcode = 6'd9;  map_addr = 12'd77;  tick("R8");
    map_we = 1'b0; tick("R8");
    // Directed microprogram
    mem[0]   = mkw(2'b00, 3'd0, 1'b0, 12'd0);        // step
    mem[1]   = mkw(2'b01, 3'd0, 1'b0, 12'd20);       // unconditional jump
    mem[20]  = mkw(2'b01, 3'd1, 1'b0, 12'd30);       // on flag 0, taken
    mem[30]  = mkw(2'b01, 3'd3, 1'b1, 12'd90);       // on !flag 2, not taken
    mem[31]  = mkw(2'b10, 3'd0, 1'b0, 12'd0);        // dispatch
    mem[40]  = mkw(2'b01, 3'd7, 1'b0, 12'hFFF);      // on flag 6 to 4095
    mem[255] = mkw(2'b00, 3'd0, 1'b0, 12'd0);        // 4095 wraps to 0
    mem[2]   = mkw(2'b10, 3'd0, 1'b0, 12'd0);        // dispatch unwritten
    load_mode = 1'b0;
    status_flags = 7'b0000101;
    tick("R8");                 // exit: word 0 latched, next 1
    tick("R4");                 // 1 -> 20
    tick("R4");                 // 20 -> 30 (flag0=1)
    tick("R5");                 // 30 -> 31 (flag2=1, inverted false)
    ir_opcode = 6'd5;
    tick("R6");                 // 31 -> map[5]=40, same-cycle opcode
    status_flags = 7'b1000000;
    tick("R4");                 // 40 -> 4095
    tick("R2");                 // 4095 -> 0
    // R9: write attempted in run mode is ignored
    map_we = 1'b1; map_opcode = 6'd3; map_addr = 12'd123;
    tick("R9");                 // 0 -> 1
    map_we = 1'b0;
    mem[1] = mkw(2'b01, 3'd0, 1'b0, 12'd2);
    tick("R4");                 // 1 -> 2
    ir_opcode = 6'd3;
    tick("R9");                 // 2 dispatch on opcode 3: still 0
    mem[0] = mkw(2'b10, 3'd0, 1'b0, 12'd0);
    ir_opcode = 6'd17;
    tick("R10");                // 0 dispatch on unwritten 17 -> 0
    mem[0] = mkw(2'b11, 3'd0, 1'b0, 12'd0);
    tick("R7");
    // Random phase
    for (int i = 0; i < 256; i++) mem[i] = {$urandom, $urandom};
    for (int n = 0; n < 4000; n++) begin
      status_flags = 7'($urandom);
      ir_opcode = ($urandom % 2) ? 6'($urandom) : (($urandom % 2) ? 6'd5 : 6'd9);
      load_mode = ($urandom % 50) == 0;
      map_we = ($urandom % 8) == 0;
      map_opcode = 6'($urandom);
      map_addr = 12'($urandom);
      tick();
    end
    load_mode = 1'b0; map_we = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule